// File: doc/BRIEF.md
# Shadow-Gated Load Address Queue

This block is a circular queue of in-flight loads that sits between the decode stage, the address-generation path and the data cache. A load takes an entry in program order as it is decoded, before its address is known. A full indication tells decode to stall. The entry later receives its computed address together with a translation outcome. A translation miss puts the entry to sleep until a wakeup pulse makes it eligible for a translation retry. Every entry carries a speculation-shadow flag. The flag is loaded at allocation and cleared later through a set of release ports driven by an external release tracker. While the flag is set, the load cannot go to the cache, cannot be retried and cannot be woken.

Each cycle the queue offers at most one load to the cache and one load for a translation retry. In both cases it picks the oldest eligible entry, counting from the head. A branch-kill input drops every entry that depends on a mispredicted branch and rolls the tail back. A commit input retires the oldest load. The depth must be a power of two.

Top module: `shadow_laq`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_idx` is 0, and `issue_valid` and `retry_valid` are 0.
- R2: An allocation is taken only when the queue is not full and no kill is present. Entries are handed out in order at index `alloc_idx`, which wraps modulo DEPTH. `full` is 1 exactly when DEPTH entries are live, and an allocation request while full changes nothing.
- R3: The shadow flag of a new entry is set to `alloc_shadowed` in the cycle of allocation. A shadowed entry never issues.
- R4: A release port with `rel_valid[p]`=1 clears the shadow flag of the entry at index `rel_idx[p*IDX_W +: IDX_W]`. If an allocation targets the same index in the same cycle, the allocation's shadow value is kept.
- R5: An address write with `addr_miss`=0 makes an unshadowed entry visible on `issue_valid`/`issue_idx`/`issue_addr` in the cycle after the write.
- R6: A shadowed entry that holds a translated address issues in the cycle after the release that clears its flag.
- R7: Among eligible entries (valid, address present, translated, unshadowed, not yet issued), the one nearest the head is offered. An entry is offered for exactly one cycle.
- R8: An address write with `addr_miss`=1 puts the entry to sleep, so it neither issues nor retries. A `tlb_wake` pulse wakes sleeping unshadowed entries. The oldest awake untranslated unshadowed entry is then offered on `retry_valid`/`retry_idx`/`retry_addr` for one cycle, after which it sleeps again until its next address write.
- R9: A `tlb_wake` pulse has no effect on a sleeping entry whose shadow flag is set. Such an entry stays asleep after its release until a later wake.
- R10: A kill invalidates every live entry whose branch mask shares a set bit with `kill_mask`, and every entry younger than the oldest such entry. The tail returns to the oldest killed index. An allocation or commit in the kill cycle is dropped.
- R11: `commit_valid` retires the head entry when the queue is not empty, which frees one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests an entry for a load |
| alloc_shadowed | input | 1 | The new load is under a speculation shadow |
| alloc_brmask | input | BR_W | Branches the new load depends on |
| alloc_idx | output | IDX_W | Index the next allocation receives (tail) |
| full | output | 1 | No free entry; stall decode |
| addr_valid | input | 1 | Address and translation result are written |
| addr_idx | input | IDX_W | Entry receiving the address |
| addr_value | input | ADDR_W | Computed address |
| addr_miss | input | 1 | Translation missed |
| rel_valid | input | REL_PORTS | Release port strobes |
| rel_idx | input | REL_PORTS*IDX_W | Entry index per release port |
| tlb_wake | input | 1 | Wake sleeping translation misses |
| kill_valid | input | 1 | Branch misprediction kill |
| kill_mask | input | BR_W | Mispredicted branch bits |
| commit_valid | input | 1 | Retire the head entry |
| issue_valid | output | 1 | A load is sent to the cache |
| issue_idx | output | IDX_W | Entry of the issued load |
| issue_addr | output | ADDR_W | Address of the issued load |
| retry_valid | output | 1 | A load is sent for translation retry |
| retry_idx | output | IDX_W | Entry of the retried load |
| retry_addr | output | ADDR_W | Address to translate again |

## Verification
Every result is registered once. A stimulus driven before a rising edge takes effect at that edge: allocation, address write, release, wake, kill or commit. Its consequence then appears on `full`, `alloc_idx`, the issue outputs and the retry outputs for the whole of the following cycle. The bench drives inputs after the falling edge and updates its own model at the rising edge. It compares every output at the next falling edge, so each check looks exactly one edge after its stimulus. The directed cases also assert literal expected values at those same points.

// File: rtl/laq_pkg.sv
package laq_pkg;
  // Position of an entry counted from the head (0 = oldest).
  function automatic int age_of(int idx, int head, int depth);
    return (idx - head + depth) % depth;
  endfunction

  // Entry index at a given age.
  function automatic int idx_at(int head, int age, int depth);
    return (head + age) % depth;
  endfunction

  // Occupancy after one cycle.
  function automatic int next_count(int base, bit commit_ok, bit alloc_ok);
    return base - int'(commit_ok) + int'(alloc_ok);
  endfunction
endpackage

// File: rtl/laq_pick.sv
module laq_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] elig,
  output logic             found,
  output logic [IDX_W-1:0] age
);
  import laq_pkg::*;

  // Scan youngest to oldest so the oldest match is written last.
  always_comb begin
    found = 1'b0;
    age   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (elig[idx_at(int'(head), k, DEPTH)]) begin
        found = 1'b1;
        age   = IDX_W'(k);
      end
    end
  end

  a_r7_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[idx_at(int'(head), int'(age), DEPTH)]);
endmodule

// File: rtl/laq_ptrs.sv
module laq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_ok,
  input  logic             commit_ok,
  input  logic             kill_valid,
  input  logic [CNT_W-1:0] keep,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import laq_pkg::*;

  logic [CNT_W-1:0] base;

  assign base = kill_valid ? keep : count;
  assign tail = IDX_W'(idx_at(int'(head), int'(count), DEPTH));
  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      head  <= IDX_W'(idx_at(int'(head), int'(commit_ok), DEPTH));
      count <= CNT_W'(next_count(int'(base), commit_ok, alloc_ok));
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r11_commit_moves_head: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> head != $past(head));
endmodule

// File: rtl/shadow_laq.sv
module shadow_laq #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int BR_W      = 4,
  parameter int REL_PORTS = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  input  logic                       alloc_shadowed,
  input  logic [BR_W-1:0]            alloc_brmask,
  output logic [IDX_W-1:0]           alloc_idx,
  output logic                       full,
  input  logic                       addr_valid,
  input  logic [IDX_W-1:0]           addr_idx,
  input  logic [ADDR_W-1:0]          addr_value,
  input  logic                       addr_miss,
  input  logic [REL_PORTS-1:0]       rel_valid,
  input  logic [REL_PORTS*IDX_W-1:0] rel_idx,
  input  logic                       tlb_wake,
  input  logic                       kill_valid,
  input  logic [BR_W-1:0]            kill_mask,
  input  logic                       commit_valid,
  output logic                       issue_valid,
  output logic [IDX_W-1:0]           issue_idx,
  output logic [ADDR_W-1:0]          issue_addr,
  output logic                       retry_valid,
  output logic [IDX_W-1:0]           retry_idx,
  output logic [ADDR_W-1:0]          retry_addr
);
  import laq_pkg::*;

  // Per-entry state
  logic [DEPTH-1:0] vld, shd, has_addr, xlated, asleep, fired;
  logic [BR_W-1:0]   brmask [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];

  // Named internal events
  logic             alloc_ok, commit_ok;
  logic [DEPTH-1:0] rel_clr, kill_hit, issue_elig, retry_elig;
  logic             kill_found;
  logic [IDX_W-1:0] kill_age, issue_age, retry_age, head, tail;
  logic [CNT_W-1:0] count, keep;

  assign alloc_ok  = alloc_valid && !full && !kill_valid;
  assign commit_ok = commit_valid && (count != '0) && !kill_valid;
  assign keep      = kill_found ? CNT_W'(kill_age) : count;
  assign alloc_idx = tail;

  always_comb begin
    rel_clr = '0;
    for (int p = 0; p < REL_PORTS; p++)
      if (rel_valid[p]) rel_clr[rel_idx[p*IDX_W +: IDX_W]] = 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign kill_hit[g]   = vld[g] && ((brmask[g] & kill_mask) != '0);
    assign issue_elig[g] = vld[g] && has_addr[g] && xlated[g] && !shd[g] && !fired[g];
    assign retry_elig[g] = vld[g] && has_addr[g] && !xlated[g] && !asleep[g] && !shd[g];
  end

  laq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_ok(alloc_ok), .commit_ok(commit_ok),
    .kill_valid(kill_valid), .keep(keep), .head(head), .tail(tail),
    .count(count), .full(full));

  laq_pick #(.DEPTH(DEPTH)) u_pick_issue (
    .clk(clk), .rst_n(rst_n), .head(head), .elig(issue_elig),
    .found(issue_valid), .age(issue_age));

  laq_pick #(.DEPTH(DEPTH)) u_pick_retry (
    .clk(clk), .rst_n(rst_n), .head(head), .elig(retry_elig),
    .found(retry_valid), .age(retry_age));

  laq_pick #(.DEPTH(DEPTH)) u_pick_kill (
    .clk(clk), .rst_n(rst_n), .head(head), .elig(kill_hit),
    .found(kill_found), .age(kill_age));

  assign issue_idx  = IDX_W'(idx_at(int'(head), int'(issue_age), DEPTH));
  assign retry_idx  = IDX_W'(idx_at(int'(head), int'(retry_age), DEPTH));
  assign issue_addr = addr_q[issue_idx];
  assign retry_addr = addr_q[retry_idx];

  // Later statements take priority: address write over wake/retry,
  // allocation over release, kill and commit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; shd <= '0; has_addr <= '0;
      xlated <= '0; asleep <= '0; fired <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        brmask[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (issue_valid && issue_idx == IDX_W'(i)) fired[i] <= 1'b1;
        if (tlb_wake && asleep[i] && !shd[i]) asleep[i] <= 1'b0;
        if (retry_valid && retry_idx == IDX_W'(i)) asleep[i] <= 1'b1;
        if (addr_valid && addr_idx == IDX_W'(i)) begin
          has_addr[i] <= 1'b1;
          xlated[i]   <= !addr_miss;
          asleep[i]   <= addr_miss;
          addr_q[i]   <= addr_value;
        end
        if (rel_clr[i]) shd[i] <= 1'b0;
        if (kill_valid && CNT_W'(age_of(i, int'(head), DEPTH)) >= keep) vld[i] <= 1'b0;
        if (commit_ok && head == IDX_W'(i)) vld[i] <= 1'b0;
        if (alloc_ok && tail == IDX_W'(i)) begin
          vld[i]      <= 1'b1;
          shd[i]      <= alloc_shadowed;
          has_addr[i] <= 1'b0;
          xlated[i]   <= 1'b0;
          asleep[i]   <= 1'b0;
          fired[i]    <= 1'b0;
          brmask[i]   <= alloc_brmask;
        end
      end
    end
  end

  a_r3_alloc_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> vld[$past(alloc_idx)] && (shd[$past(alloc_idx)] == $past(alloc_shadowed)));
  a_r6_issue_unshadowed: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> vld[issue_idx] && xlated[issue_idx] && !shd[issue_idx]);
  a_r8_retry_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid && !(addr_valid && addr_idx == retry_idx) |=> asleep[$past(retry_idx)]);

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    a_r10_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kill_valid && kill_hit[g] |=> !vld[g]);
    a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rel_clr[g] && !(alloc_ok && alloc_idx == IDX_W'(g)) |=> !shd[g]);
  end
endmodule

// File: tb/shadow_laq_test.sv
`timescale 1ns/1ps
module shadow_laq_test;
  localparam int D = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid, alloc_shadowed, addr_valid, addr_miss, tlb_wake, kill_valid, commit_valid;
  logic [3:0] alloc_brmask, kill_mask;
  logic [IW-1:0] alloc_idx, addr_idx, issue_idx, retry_idx;
  logic full, issue_valid, retry_valid;
  logic [31:0] addr_value, issue_addr, retry_addr;
  logic [1:0] rel_valid;
  logic [2*IW-1:0] rel_idx;

  shadow_laq uut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // Bench model of the queue
  int mh = 0, mc = 0;
  bit mv[D], ms[D], ma[D], mx[D], mz[D], mf[D];
  logic [3:0] mm[D];
  logic [31:0] md[D];

  function automatic int m_tail();
    return (mh + mc) % D;
  endfunction

  // kind 0: cache issue, 1: retry, 2: kill; returns age or -1
  function automatic int m_pick(int kind);
    for (int k = 0; k < D; k++) begin
      int i = (mh + k) % D;
      bit e;
      case (kind)
        0: e = mv[i] && ma[i] && mx[i] && !ms[i] && !mf[i];
        1: e = mv[i] && ma[i] && !mx[i] && !mz[i] && !ms[i];
        default: e = mv[i] && ((mm[i] & kill_mask) != 0);
      endcase
      if (e) return k;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    int iss = m_pick(0), rty = m_pick(1), kk = m_pick(2);
    int keep = kill_valid ? ((kk < 0) ? mc : kk) : mc;
    bit aok = alloc_valid && mc < D && !kill_valid;
    bit cok = commit_valid && mc > 0 && !kill_valid;
    int t = m_tail();
    for (int i = 0; i < D; i++) begin
      int age = (i - mh + D) % D;
      if (iss >= 0 && i == (mh + iss) % D) mf[i] = 1;
      if (tlb_wake && mz[i] && !ms[i]) mz[i] = 0;
      if (rty >= 0 && i == (mh + rty) % D) mz[i] = 1;
      if (addr_valid && int'(addr_idx) == i) begin
        ma[i] = 1; mx[i] = !addr_miss; mz[i] = addr_miss; md[i] = addr_value;
      end
      for (int p = 0; p < 2; p++)
        if (rel_valid[p] && int'(rel_idx[p*IW +: IW]) == i) ms[i] = 0;
      if (kill_valid && age >= keep) mv[i] = 0;
      if (cok && i == mh) mv[i] = 0;
      if (aok && i == t) begin
        mv[i] = 1; ms[i] = alloc_shadowed; ma[i] = 0; mx[i] = 0;
        mz[i] = 0; mf[i] = 0; mm[i] = alloc_brmask;
      end
    end
    mc = keep - int'(cok) + int'(aok);
    mh = (mh + int'(cok)) % D;
  endtask

  task automatic compare();
    int iss = m_pick(0), rty = m_pick(1);
    chk(full === (mc == D), "R2 full", full, mc == D);
    chk(alloc_idx === IW'(m_tail()), "R2 alloc_idx", alloc_idx, m_tail());
    chk(issue_valid === (iss >= 0), "R7 issue_valid", issue_valid, iss >= 0);
    if (iss >= 0) begin
      chk(issue_idx === IW'((mh + iss) % D), "R7 issue_idx", issue_idx, (mh + iss) % D);
      chk(issue_addr === md[(mh + iss) % D], "R5 issue_addr", issue_addr, md[(mh + iss) % D]);
    end
    chk(retry_valid === (rty >= 0), "R8 retry_valid", retry_valid, rty >= 0);
    if (rty >= 0) begin
      chk(retry_idx === IW'((mh + rty) % D), "R8 retry_idx", retry_idx, (mh + rty) % D);
      chk(retry_addr === md[(mh + rty) % D], "R8 retry_addr", retry_addr, md[(mh + rty) % D]);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_shadowed = 0; alloc_brmask = 0;
    addr_valid = 0; addr_idx = 0; addr_value = 0; addr_miss = 0;
    rel_valid = 0; rel_idx = 0; tlb_wake = 0;
    kill_valid = 0; kill_mask = 0; commit_valid = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic do_alloc(bit sh, logic [3:0] m);
    alloc_valid = 1; alloc_shadowed = sh; alloc_brmask = m; tick();
  endtask
  task automatic do_addr(int i, logic [31:0] a, bit miss);
    addr_valid = 1; addr_idx = IW'(i); addr_value = a; addr_miss = miss; tick();
  endtask
  task automatic do_rel(int i);
    rel_valid = 2'b10; rel_idx[IW +: IW] = IW'(i); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(full === 0 && alloc_idx === 0, "R1 empty", {full, alloc_idx}, 0);
    chk(issue_valid === 0 && retry_valid === 0, "R1 idle outputs", {issue_valid, retry_valid}, 0);

    do_alloc(1, 4'b0001);                     // idx0 shadowed
    do_alloc(0, 4'b0010);                     // idx1 clear
    do_addr(1, 32'h100, 0);
    chk(issue_valid === 1 && issue_idx === 1 && issue_addr === 32'h100, "R5 issue after hit", issue_idx, 1);
    tick();
    chk(issue_valid === 0, "R7 issued once", issue_valid, 0);
    do_addr(0, 32'h200, 0);
    chk(issue_valid === 0, "R3 shadowed holds", issue_valid, 0);
    do_rel(0);
    chk(issue_valid === 1 && issue_idx === 0 && issue_addr === 32'h200, "R6 issue after release", issue_idx, 0);
    tick();

    // R4: allocation beats release to the same index
    alloc_valid = 1; alloc_shadowed = 1; alloc_brmask = 4'b0001;
    rel_valid = 2'b01; rel_idx[IW-1:0] = 3'd2; tick();
    do_addr(2, 32'h300, 0);
    chk(issue_valid === 0, "R4 alloc wins", issue_valid, 0);
    do_rel(2);
    chk(issue_valid === 1 && issue_idx === 2, "R4 later release", issue_idx, 2);
    tick();

    // R8: miss, wake, retry, refill
    do_alloc(0, 4'b0001);                     // idx3
    do_addr(3, 32'h400, 1);
    chk(issue_valid === 0 && retry_valid === 0, "R8 asleep", {issue_valid, retry_valid}, 0);
    tlb_wake = 1; tick();
    chk(retry_valid === 1 && retry_idx === 3 && retry_addr === 32'h400, "R8 retry offered", retry_idx, 3);
    tick();
    chk(retry_valid === 0, "R8 sleeps after retry", retry_valid, 0);
    do_addr(3, 32'h404, 0);
    chk(issue_valid === 1 && issue_idx === 3 && issue_addr === 32'h404, "R8 issue after refill", issue_addr, 32'h404);
    tick();

    // R9: wake ignored while shadowed
    do_alloc(1, 4'b0001);                     // idx4
    do_addr(4, 32'h500, 1);
    tlb_wake = 1; tick();
    chk(retry_valid === 0, "R9 wake while shadowed", retry_valid, 0);
    do_rel(4);
    chk(retry_valid === 0, "R9 still asleep", retry_valid, 0);
    tlb_wake = 1; tick();
    chk(retry_valid === 1 && retry_idx === 4, "R9 wake after release", retry_idx, 4);
    tick();

    // R10: kill rolls the tail back, allocation in that cycle dropped
    do_alloc(0, 4'b0100);                     // idx5
    do_alloc(0, 4'b0100);                     // idx6
    kill_valid = 1; kill_mask = 4'b0100; alloc_valid = 1; tick();
    chk(alloc_idx === 5 && full === 0, "R10 tail rollback", alloc_idx, 5);

    // R11 / R2: drain, fill, overfill
    for (int n = 0; n < 5; n++) begin commit_valid = 1; tick(); end
    for (int n = 0; n < 8; n++) do_alloc(0, 4'b1000);
    chk(full === 1 && alloc_idx === 5, "R2 full at depth", {full, alloc_idx}, {1'b1, 3'd5});
    do_alloc(0, 4'b1000);
    chk(full === 1 && alloc_idx === 5, "R2 alloc ignored when full", alloc_idx, 5);
    commit_valid = 1; tick();
    chk(full === 0 && alloc_idx === 5, "R11 commit frees slot", full, 0);
    kill_valid = 1; kill_mask = 4'b1000; tick();
    chk(alloc_idx === 6 && full === 0, "R10 kill all", alloc_idx, 6);

    // Constrained random phase
    for (int c = 0; c < 4000; c++) begin
      alloc_valid = ($urandom % 3) != 0;
      alloc_shadowed = $urandom % 2;
      alloc_brmask = 4'($urandom % 16);
      begin
        int i = $urandom % D;
        if (mv[i] && !mx[i] && ($urandom % 2)) begin
          addr_valid = 1; addr_idx = IW'(i);
          addr_value = $urandom; addr_miss = ($urandom % 3) == 0;
        end
      end
      for (int p = 0; p < 2; p++) begin
        rel_valid[p] = ($urandom % 3) == 0;
        rel_idx[p*IW +: IW] = IW'($urandom % D);
      end
      tlb_wake = ($urandom % 4) == 0;
      kill_valid = ($urandom % 20) == 0;
      kill_mask = 4'(1 << ($urandom % 4));
      commit_valid = ($urandom % 3) == 0;
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule